// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives serial PCM audio as a slave. It is given one shared bit clock, one shared word clock and a set of serial data lanes, with one stereo pair per lane. From these it produces a parallel left sample and a parallel right sample for each lane. All three lanes are decoded in lockstep. Once per complete frame, every lane's left and right results update in the same cycle, and a single-cycle valid strobe marks the update. The serial inputs are brought into the system clock domain through a synchronizer. Each rising edge of the bit clock becomes one bit event.

Two static selects set the framing. The first chooses between the delayed-MSB format (I2S), left-justified and right-justified. The second chooses a word length of 16, 20 or 24 bits. If a frame has exactly sixteen bit clocks in each word-clock phase, the block decodes it as 16-bit data, whatever length is selected. A framing flag is reported with every frame. It is raised when a phase has too few bit clocks to carry a full word.

The sample output carries a valid strobe and has no ready signal. Audio arrives at the rate the source sets, so the block cannot apply back-pressure. A consumer must take the samples in the cycle of the strobe, or within one frame time, because the outputs hold their values until the next strobe. The selects may change only while reset is asserted.

Top module: `ser_audio_rx`

## Requirements
- R1: The word clock and every data lane are sampled on the rising edge of the bit clock, and words arrive MSB first. Per frame, `valid_o` is high for exactly one clock, and every lane's left and right outputs change only in that cycle.
- R2: With `fmt_sel_i` = 2'b01 (left-justified), the MSB is the bit on the first rising edge after a word-clock change. Word clock high is the left channel, and bits after the word length are ignored.
- R3: With `fmt_sel_i` = 2'b00, or the reserved value 2'b11 (I2S), the MSB is the bit on the second rising edge after a word-clock change, and word clock low is the left channel.
- R4: With `fmt_sel_i` = 2'b10 (right-justified), the LSB is the bit on the last rising edge before a word-clock change, and word clock high is the left channel. Only the last word-length bits of a phase are kept, and earlier padding bits are dropped.
- R5: `wlen_sel_i` encodes the word length as 2'b00 = 16, 2'b01 = 20, and 2'b10 or 2'b11 = 24. Each output is a 24-bit field with the word left-aligned at bit 23 and the unused low bits zero.
- R6: When both phases of a frame have exactly 16 bit clocks, the frame is decoded as 16-bit words, whatever `wlen_sel_i` selects.
- R7: `frame_err_o` updates together with `valid_o`. It is 1 when either phase of that frame had fewer bit clocks than the word length in force for the frame, and 0 otherwise. Between strobes it holds its value.
- R8: The phase in progress when reset is released is discarded. A strobe is issued only for a left phase followed by a right phase, both complete and both starting after a word-clock change, so a right phase with no complete left phase before it produces no strobe.
- R9: While reset is asserted, and after it until the first strobe, `valid_o`, `frame_err_o` and all sample outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Serial bit clock (asynchronous to clk) |
| wsel_i | input | 1 | Word clock selecting the channel |
| sdata_i | input | NUM_LANES | Serial data, one lane per stereo pair |
| fmt_sel_i | input | 2 | Framing format: 00/11 I2S, 01 left-justified, 10 right-justified |
| wlen_sel_i | input | 2 | Word length: 00 16, 01 20, 10/11 24 bits |
| left_o | output | 24*NUM_LANES | Left samples; lane k at bits [24k+23:24k] |
| right_o | output | 24*NUM_LANES | Right samples; lane k at bits [24k+23:24k] |
| valid_o | output | 1 | One-clock strobe when a new frame is presented |
| frame_err_o | output | 1 | Framing flag for the frame last presented |

## Verification
The hardest case to reach is a phase boundary where the selected word length, the automatic 16-bit switch and the framing flag disagree. One example is a 16/17 frame with 24 bits selected: it is not auto-detected, so it must be flagged. The bench drives whole bit streams from a queue and picks the phase lengths per frame. It mixes random lengths between the word length and 32 with directed frames of exactly 16/16, 16/17 and too-short phases, in every format. The I2S stream is built by offsetting the word clock one bit ahead of the data. A segment that opens in the middle of a left phase exercises the discard of partial phases.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

  localparam int SAMPLE_W = 24;

  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_ALT = 2'b11
  } fmt_e;

  // word length in bits from the length select
  function automatic logic [4:0] wlen_bits(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd16;
      2'b01:   return 5'd20;
      default: return 5'd24;
    endcase
  endfunction

  // place the low len bits of raw at the top of the field, zero below
  function automatic logic [SAMPLE_W-1:0] left_align(input logic [SAMPLE_W-1:0] raw,
                                                     input logic [4:0] len);
    case (len)
      5'd16:   return {raw[15:0], 8'h00};
      5'd20:   return {raw[19:0], 4'h0};
      default: return raw;
    endcase
  endfunction

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int LANES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             ws_i,
  input  logic [LANES-1:0] sd_i,
  output logic             bit_evt_o,
  output logic             ws_o,
  output logic [LANES-1:0] sd_o
);
  localparam int VW = LANES + 2;

  logic [VW-1:0] stg [STAGES];
  logic          sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      sclk_q <= 1'b0;
    end else begin
      stg[0] <= {sd_i, ws_i, sclk_i};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      sclk_q <= stg[STAGES-1][0];
    end
  end

  // bit clock rising edge, seen in the clk domain; data from the same stage
  assign bit_evt_o = stg[STAGES-1][0] & ~sclk_q;
  assign ws_o      = stg[STAGES-1][1];
  assign sd_o      = stg[STAGES-1][VW-1:2];
endmodule

// File: rtl/sarx_framer.sv
module sarx_framer
  import sarx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_evt_i,
  input  logic       ws_i,
  input  logic [1:0] fmt_sel_i,
  input  logic [1:0] wlen_sel_i,
  output logic       trans_o,
  output logic       shift_en_o,
  output logic       cap_left_o,
  output logic       frame_o,
  output logic [4:0] eff_len_o,
  output logic       valid_o,
  output logic       frame_err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_16  = CNT_W'(16);

  logic             ws_d1, e_prev, started, have_left;
  logic [1:0]       prime;
  logic [CNT_W-1:0] cnt, left_len;
  logic             is_i2s, is_rj, e_cur, primed, ended_left, auto16;
  logic [4:0]       sel_len;
  logic [CNT_W-1:0] eff_w;

  assign is_i2s  = (fmt_sel_i == FMT_I2S) || (fmt_sel_i == FMT_ALT);
  assign is_rj   = (fmt_sel_i == FMT_RJ);
  // I2S is left-justified against a word clock delayed by one bit
  assign e_cur   = is_i2s ? ws_d1 : ws_i;
  assign primed  = (prime == 2'd2);
  assign sel_len = wlen_bits(wlen_sel_i);

  assign trans_o    = bit_evt_i && primed && (e_cur != e_prev);
  assign ended_left = is_i2s ? ~e_prev : e_prev;
  assign cap_left_o = trans_o && started && ended_left;
  assign frame_o    = trans_o && started && !ended_left && have_left;

  assign auto16    = (left_len == CNT_16) && (cnt == CNT_16);
  assign eff_len_o = auto16 ? 5'd16 : sel_len;
  assign eff_w     = CNT_W'(eff_len_o);

  assign shift_en_o = bit_evt_i && (trans_o || is_rj || (cnt < CNT_W'(sel_len)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_d1       <= 1'b0;
      e_prev      <= 1'b0;
      prime       <= 2'd0;
      started     <= 1'b0;
      have_left   <= 1'b0;
      cnt         <= '0;
      left_len    <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o <= frame_o;
      if (frame_o) frame_err_o <= (left_len < eff_w) || (cnt < eff_w);
      if (bit_evt_i) begin
        ws_d1  <= ws_i;
        e_prev <= e_cur;
        if (!primed) prime <= prime + 2'd1;
        if (trans_o) begin
          cnt     <= CNT_W'(1);
          started <= 1'b1;
          if (cap_left_o) begin
            left_len  <= cnt;
            have_left <= 1'b1;
          end
          if (frame_o) have_left <= 1'b0;
        end else if (cnt != CNT_MAX) begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sarx_lane.sv
module sarx_lane
  import sarx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_i,
  input  logic                trans_i,
  input  logic                shift_en_i,
  input  logic                cap_left_i,
  input  logic                frame_i,
  input  logic [4:0]          eff_len_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);
  logic [SAMPLE_W-1:0] sh, lhold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh      <= '0;
      lhold   <= '0;
      left_o  <= '0;
      right_o <= '0;
    end else begin
      if (trans_i)         sh <= {{(SAMPLE_W-1){1'b0}}, bit_i};
      else if (shift_en_i) sh <= {sh[SAMPLE_W-2:0], bit_i};
      if (cap_left_i) lhold <= sh;
      if (frame_i) begin
        left_o  <= left_align(lhold, eff_len_i);
        right_o <= left_align(sh, eff_len_i);
      end
    end
  end
endmodule

// File: rtl/ser_audio_rx.sv
module ser_audio_rx
  import sarx_pkg::*;
#(
  parameter int NUM_LANES   = 3,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sclk_i,
  input  logic                          wsel_i,
  input  logic [NUM_LANES-1:0]          sdata_i,
  input  logic [1:0]                    fmt_sel_i,
  input  logic [1:0]                    wlen_sel_i,
  output logic [NUM_LANES*SAMPLE_W-1:0] left_o,
  output logic [NUM_LANES*SAMPLE_W-1:0] right_o,
  output logic                          valid_o,
  output logic                          frame_err_o
);
  logic                 bit_evt, ws_s, trans, shift_en, cap_left, frame;
  logic [NUM_LANES-1:0] sd_s;
  logic [4:0]           eff_len;

  sarx_sync #(.LANES(NUM_LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .ws_i(wsel_i), .sd_i(sdata_i),
    .bit_evt_o(bit_evt), .ws_o(ws_s), .sd_o(sd_s)
  );

  sarx_framer #(.CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .bit_evt_i(bit_evt), .ws_i(ws_s),
    .fmt_sel_i(fmt_sel_i), .wlen_sel_i(wlen_sel_i),
    .trans_o(trans), .shift_en_o(shift_en), .cap_left_o(cap_left),
    .frame_o(frame), .eff_len_o(eff_len), .valid_o(valid_o),
    .frame_err_o(frame_err_o)
  );

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    sarx_lane u_lane (
      .clk(clk), .rst_n(rst_n), .bit_i(sd_s[k]), .trans_i(trans),
      .shift_en_i(shift_en), .cap_left_i(cap_left), .frame_i(frame),
      .eff_len_i(eff_len),
      .left_o(left_o[k*SAMPLE_W +: SAMPLE_W]),
      .right_o(right_o[k*SAMPLE_W +: SAMPLE_W])
    );
  end
endmodule

// File: rtl/sarx_checker.sv
module sarx_checker #(
  parameter int NUM_LANES = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bit_evt,
  input logic                    valid_o,
  input logic                    frame_err_o,
  input logic [1:0]              wlen_sel_i,
  input logic [NUM_LANES*24-1:0] left_o,
  input logic [NUM_LANES*24-1:0] right_o
);
  logic low8_any, low4_any;

  always_comb begin
    low8_any = 1'b0;
    low4_any = 1'b0;
    for (int k = 0; k < NUM_LANES; k++) begin
      low8_any = low8_any | (|left_o[k*24 +: 8]) | (|right_o[k*24 +: 8]);
      low4_any = low4_any | (|left_o[k*24 +: 4]) | (|right_o[k*24 +: 4]);
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R1
  AST_VALID_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(bit_evt)); // R1
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o))); // R1
  AST_LOW_ZERO_16: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && wlen_sel_i == 2'b00) |-> !low8_any); // R5
  AST_LOW_ZERO_20: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && wlen_sel_i == 2'b01) |-> !low4_any); // R5
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(frame_err_o)); // R7
endmodule

bind ser_audio_rx sarx_checker #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_evt(bit_evt), .valid_o(valid_o),
  .frame_err_o(frame_err_o), .wlen_sel_i(wlen_sel_i),
  .left_o(left_o), .right_o(right_o)
);

// File: tb/ser_audio_rx_tb_top.sv
module ser_audio_rx_tb_top;
  localparam int NL = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sclk = 1'b0, ws = 1'b0;
  logic [NL-1:0] sd = '0;
  logic [1:0]    fmt = 2'b00, wlen = 2'b10;
  logic [NL*24-1:0] left_o, right_o;
  logic          valid_o, frame_err_o;

  always #5 clk = ~clk;

  ser_audio_rx dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .wsel_i(ws), .sdata_i(sd),
    .fmt_sel_i(fmt), .wlen_sel_i(wlen), .left_o(left_o), .right_o(right_o),
    .valid_o(valid_o), .frame_err_o(frame_err_o)
  );

  typedef struct { logic [NL*24-1:0] l; logic [NL*24-1:0] r; bit err; bit dchk; } exp_t;
  exp_t          exp_q[$];
  bit            q_ws[$];
  logic [NL-1:0] q_sd[$];
  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [NL*24-1:0] act, input logic [NL*24-1:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic bit is_i2s(input logic [1:0] f);
    return (f == 2'b00) || (f == 2'b11);
  endfunction

  function automatic int sel_len(input logic [1:0] w);
    return (w == 2'b00) ? 16 : (w == 2'b01) ? 20 : 24;
  endfunction

  // one phase of P bits; words of L bits laid out per format
  task automatic add_phase(input bit lvl, input int p, input int l, input logic [23:0] w [NL]);
    for (int i = 0; i < p; i++) begin
      logic [NL-1:0] b;
      for (int k = 0; k < NL; k++) begin
        int j;
        j = (fmt == 2'b10) ? i - (p - l) : i;
        b[k] = (j >= 0 && j < l) ? w[k][l-1-j] : 1'b0;
      end
      q_ws.push_back(lvl);
      q_sd.push_back(b);
    end
  endtask

  task automatic add_frame(input int len_l, input int len_r);
    logic [23:0] wl [NL];
    logic [23:0] wr [NL];
    exp_t e;
    int eff;
    bit left_lvl;
    eff = (len_l == 16 && len_r == 16) ? 16 : sel_len(wlen);
    for (int k = 0; k < NL; k++) begin
      wl[k] = $urandom() & ((24'd1 << eff) - 24'd1);
      wr[k] = $urandom() & ((24'd1 << eff) - 24'd1);
      e.l[k*24 +: 24] = wl[k] << (24 - eff);
      e.r[k*24 +: 24] = wr[k] << (24 - eff);
    end
    left_lvl = !is_i2s(fmt);
    add_phase(left_lvl, len_l, eff, wl);
    add_phase(!left_lvl, len_r, eff, wr);
    e.err  = (len_l < eff) || (len_r < eff);
    e.dchk = !e.err;
    exp_q.push_back(e);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sclk  = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic begin_seg(input logic [1:0] f, input logic [1:0] w, input bit lead_left);
    logic [23:0] z [NL];
    for (int k = 0; k < NL; k++) z[k] = '0;
    fmt  = f;
    wlen = w;
    do_reset();
    q_ws.delete();
    q_sd.delete();
    exp_q.delete();
    if (lead_left) begin
      // partial left phase, then a right phase with no left before it (R8)
      add_phase(!is_i2s(f), 10, 16, z);
      add_phase(is_i2s(f), 24, 16, z);
    end else begin
      add_phase(is_i2s(f), 5, 16, z);
    end
  endtask

  task automatic play();
    logic [23:0] z [NL];
    for (int k = 0; k < NL; k++) z[k] = '0;
    add_phase(!is_i2s(fmt), 3, 16, z);
    for (int n = 0; n < q_ws.size(); n++) begin
      @(negedge clk);
      sclk = 1'b0;
      // in I2S the word clock leads the data by one bit
      ws = is_i2s(fmt) ? q_ws[(n + 1 < q_ws.size()) ? n + 1 : n] : q_ws[n];
      sd = q_sd[n];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "frames not delivered", exp_q.size(), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(frame_err_o == e.err, "R7", "frame_err", frame_err_o, e.err);
        if (e.dchk) begin
          chk(left_o == e.l, is_i2s(fmt) ? "R3" : (fmt == 2'b01 ? "R2" : "R4"),
              "left samples R1 R5", left_o, e.l);
          chk(right_o == e.r, is_i2s(fmt) ? "R3" : (fmt == 2'b01 ? "R2" : "R4"),
              "right samples R1 R5", right_o, e.r);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    do_reset();
    // R9 reset state
    chk(valid_o == 1'b0, "R9", "valid after reset", valid_o, 0);
    chk(frame_err_o == 1'b0, "R9", "err after reset", frame_err_o, 0);
    chk(left_o == '0 && right_o == '0, "R9", "samples after reset", left_o | right_o, 0);

    // random phase lengths, every format code and word length (R2 R3 R4 R5)
    for (int f = 0; f < 4; f++) begin
      for (int w = 0; w < 4; w++) begin
        int sl;
        begin_seg(f[1:0], w[1:0], 1'b0);
        sl = sel_len(w[1:0]);
        for (int i = 0; i < 3; i++)
          add_frame(sl + int'($urandom() % (33 - sl)), sl + int'($urandom() % (33 - sl)));
        play();
      end
    end

    // R6 automatic 16-bit at 16/16, not at 16/17 (that one is short, R7)
    for (int f = 0; f < 3; f++) begin
      begin_seg(f[1:0], 2'b10, 1'b0);
      add_frame(16, 16);
      add_frame(16, 17);
      add_frame(16, 16);
      add_frame(24, 24);
      play();
    end

    // R7 short phases and exact fits; R4 long padding
    begin_seg(2'b10, 2'b01, 1'b0);
    add_frame(18, 24);
    add_frame(20, 20);
    add_frame(32, 19);
    add_frame(32, 32);
    play();

    // R8 reset released inside a left phase
    for (int f = 0; f < 3; f++) begin
      begin_seg(f[1:0], 2'b00, 1'b1);
      add_frame(16, 32);
      add_frame(32, 16);
      play();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule